// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block drives the data bus of an eight-input interrupt controller while the CPU runs its interrupt acknowledge cycles. It watches the active-low acknowledge strobe and counts its pulses. On the first pulse it freezes the IR number chosen by the priority resolver. It then returns the bytes the CPU expects, one per pulse. It also tells the in-service register when to set the winner's bit and, in automatic end-of-interrupt mode, when to clear it again.

Two CPU styles are supported. An 8-bit CPU takes three acknowledge pulses. The first returns a CALL opcode. The second returns the low byte of the handler address, built from programmed upper address bits and the frozen IR number at a spacing of 4 or 8 bytes. The third returns the programmed high address byte. A 16-bit CPU takes two pulses. The first only freezes the winner, and the second returns a vector byte whose low three bits are the IR number.

Top module: `ivs_ack_seq`

## Requirements
- R1: After reset `dout_oe`, `isr_set` and `isr_clr` are low, and the next acknowledge pulse is treated as the first of a sequence.
- R2: With `cpu8_mode`=1, the first acknowledge pulse drives 8'hCD on `dout` with `dout_oe` high.
- R3: With `cpu8_mode`=1 and `intvl4`=1, the second pulse drives `{lo_cfg[7:5], irq[2:0], 2'b00}`.
- R4: With `cpu8_mode`=1 and `intvl4`=0, the second pulse drives `{lo_cfg[7:6], irq[2:0], 3'b000}`.
- R5: With `cpu8_mode`=1, the third pulse drives `vec_hi` unchanged.
- R6: With `cpu8_mode`=0, the first pulse leaves `dout_oe` low, and the second pulse drives `{vec_hi[7:3], irq[2:0]}`.
- R7: In the clock cycle after the first pulse's leading edge is sampled, `isr_set` is high for exactly one cycle, and `isr_idx` equals `win_irq` as sampled at that edge. The frozen number is used for the rest of the sequence, even if `win_irq` changes.
- R8: With `aeoi`=1, `isr_clr` pulses high for one cycle, in the cycle after the trailing edge of the last pulse is sampled (third pulse for `cpu8_mode`=1, second pulse for `cpu8_mode`=0). With `aeoi`=0, `isr_clr` stays low.
- R9: `dout_oe` is high only while `inta_n` is low. It is low between pulses.
- R10: After the last pulse of a sequence, the next pulse starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inta_n | input | 1 | Active-low acknowledge strobe, synchronous to clk |
| win_irq | input | 3 | Winning IR number from the priority resolver |
| cpu8_mode | input | 1 | 1 = three-pulse 8-bit CPU sequence, 0 = two-pulse 16-bit CPU sequence |
| intvl4 | input | 1 | 1 = 4-byte handler spacing, 0 = 8-byte spacing |
| aeoi | input | 1 | Automatic end-of-interrupt enable |
| lo_cfg | input | 8 | Programmed upper bits of the handler address low byte |
| vec_hi | input | 8 | Handler high byte (8-bit CPU) or vector base (16-bit CPU) |
| dout | output | 8 | Data byte for the bus |
| dout_oe | output | 1 | Bus drive enable |
| isr_set | output | 1 | One-cycle request to set the in-service bit |
| isr_clr | output | 1 | One-cycle request to clear the in-service bit |
| isr_idx | output | 3 | IR number frozen for this sequence |

## Verification
The pulse index and the frozen IR number are the only internal state. Both show up at the ports within the next acknowledge pulse. A wrong index drives the wrong byte class, or leaves the bus undriven, on the very next low strobe. It also moves the `isr_clr` pulse to the wrong trailing edge. A wrong frozen number shows in the low byte or vector byte of the same sequence, and on `isr_idx` one cycle after the first leading edge.

// File: rtl/ivs_pkg.sv
package ivs_pkg;

    localparam int IRW = 3;
    localparam int PW  = 2;
    localparam logic [7:0] CALL_OP = 8'hCD;

    typedef struct packed {
        logic [PW-1:0]  idx;
        logic [IRW-1:0] irq;
        logic           set;
        logic           clr;
    } seq_t;

endpackage

// File: rtl/ivs_strobe_edge.sv
module ivs_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic lead,
    output logic trail
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = strobe_n;
        lead   = prev_q && !strobe_n;
        trail  = !prev_q && strobe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/ivs_byte_form.sv
module ivs_byte_form #(
    parameter int DW  = 8,
    parameter int IRW = 3,
    parameter int PW  = 2
) (
    input  logic [PW-1:0]  phase,
    input  logic           cpu8,
    input  logic           intvl4,
    input  logic [IRW-1:0] irq,
    input  logic [DW-1:0]  lo_cfg,
    input  logic [DW-1:0]  vec_hi,
    output logic [DW-1:0]  byte_o,
    output logic           supplies
);

    localparam int SP4 = 2;
    localparam int SP8 = 3;

    logic [DW-1:0] lo4, lo8, vec16;

    always_comb begin
        lo4   = {lo_cfg[DW-1:IRW+SP4], irq, {SP4{1'b0}}};
        lo8   = {lo_cfg[DW-1:IRW+SP8], irq, {SP8{1'b0}}};
        vec16 = {vec_hi[DW-1:IRW], irq};
        byte_o   = '0;
        supplies = 1'b0;
        if (cpu8) begin
            case (phase)
                2'd0: begin byte_o = DW'(ivs_pkg::CALL_OP); supplies = 1'b1; end
                2'd1: begin byte_o = intvl4 ? lo4 : lo8;     supplies = 1'b1; end
                2'd2: begin byte_o = vec_hi;                 supplies = 1'b1; end
                default: ;
            endcase
        end else if (phase == 2'd1) begin
            byte_o   = vec16;
            supplies = 1'b1;
        end
    end

endmodule

// File: rtl/ivs_ack_seq.sv
module ivs_ack_seq #(
    parameter int DW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    inta_n,
    input  logic [ivs_pkg::IRW-1:0] win_irq,
    input  logic                    cpu8_mode,
    input  logic                    intvl4,
    input  logic                    aeoi,
    input  logic [DW-1:0]           lo_cfg,
    input  logic [DW-1:0]           vec_hi,
    output logic [DW-1:0]           dout,
    output logic                    dout_oe,
    output logic                    isr_set,
    output logic                    isr_clr,
    output logic [ivs_pkg::IRW-1:0] isr_idx
);

    import ivs_pkg::*;

    localparam logic [PW-1:0] LAST8  = PW'(2);
    localparam logic [PW-1:0] LAST16 = PW'(1);

    logic lead, trail, last, supplies;
    seq_t seq_d, seq_q;

    ivs_strobe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (inta_n),
        .lead     (lead),
        .trail    (trail)
    );

    ivs_byte_form #(.DW(DW), .IRW(IRW), .PW(PW)) u_form (
        .phase    (seq_q.idx),
        .cpu8     (cpu8_mode),
        .intvl4   (intvl4),
        .irq      (seq_q.irq),
        .lo_cfg   (lo_cfg),
        .vec_hi   (vec_hi),
        .byte_o   (dout),
        .supplies (supplies)
    );

    always_comb begin
        last      = (seq_q.idx == (cpu8_mode ? LAST8 : LAST16));
        seq_d     = seq_q;
        seq_d.set = 1'b0;
        seq_d.clr = 1'b0;
        if (lead && seq_q.idx == '0) begin
            seq_d.irq = win_irq;
            seq_d.set = 1'b1;
        end
        if (trail) begin
            if (last) begin
                seq_d.idx = '0;
                seq_d.clr = aeoi;
            end else begin
                seq_d.idx = seq_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign dout_oe = !inta_n && supplies;
    assign isr_set = seq_q.set;
    assign isr_clr = seq_q.clr;
    assign isr_idx = seq_q.irq;

endmodule

// File: rtl/ivs_ack_seq_chk.sv
module ivs_ack_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic inta_n,
    input logic aeoi,
    input logic dout_oe,
    input logic isr_set,
    input logic isr_clr
);

    // R9
    oe_only_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> !inta_n);

    // R7
    set_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isr_set |=> !isr_set);

    // R7
    set_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isr_set |-> !$past(inta_n));

    // R8
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isr_clr |=> !isr_clr);

    // R8
    clr_needs_aeoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isr_clr |-> $past(aeoi));

    // R10
    set_clr_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(isr_set && isr_clr));

endmodule

bind ivs_ack_seq ivs_ack_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .inta_n  (inta_n),
    .aeoi    (aeoi),
    .dout_oe (dout_oe),
    .isr_set (isr_set),
    .isr_clr (isr_clr)
);

// File: tb/ivs_ack_seq_bench.sv
module ivs_ack_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       inta_n = 1'b1;
    logic [2:0] win_irq = '0;
    logic       cpu8_mode = 1'b1;
    logic       intvl4 = 1'b1;
    logic       aeoi = 1'b0;
    logic [7:0] lo_cfg = '0;
    logic [7:0] vec_hi = '0;
    logic [7:0] dout;
    logic       dout_oe, isr_set, isr_clr;
    logic [2:0] isr_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ivs_ack_seq u_ivs_ack_seq (
        .clk(clk), .rst_n(rst_n), .inta_n(inta_n), .win_irq(win_irq),
        .cpu8_mode(cpu8_mode), .intvl4(intvl4), .aeoi(aeoi),
        .lo_cfg(lo_cfg), .vec_hi(vec_hi), .dout(dout), .dout_oe(dout_oe),
        .isr_set(isr_set), .isr_clr(isr_clr), .isr_idx(isr_idx)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One acknowledge pulse: low for three cycles, then high for two.
    task automatic pulse(input bit exp_oe, input logic [7:0] exp_d, input string tag,
                         output bit saw_set, output bit saw_clr);
        @(negedge clk) inta_n = 1'b0;
        @(negedge clk);
        check({tag, " oe"}, dout_oe, exp_oe);
        if (exp_oe) check({tag, " data"}, dout, exp_d);
        saw_set = isr_set;
        @(negedge clk);
        check("R7 set width", isr_set, 1'b0);
        @(negedge clk) inta_n = 1'b1;
        @(negedge clk);
        saw_clr = isr_clr;
        check("R9 oe between pulses", dout_oe, 1'b0);
    endtask

    task automatic t_reset;
        check("R1 oe", dout_oe, 1'b0);
        check("R1 set", isr_set, 1'b0);
        check("R1 clr", isr_clr, 1'b0);
    endtask

    task automatic t_cpu8_int4;
        bit s, c;
        cpu8_mode = 1; intvl4 = 1; aeoi = 1; lo_cfg = 8'hA0; vec_hi = 8'h12; win_irq = 3'd5;
        pulse(1, 8'hCD, "R2 call", s, c);
        check("R7 set pulse", s, 1'b1);
        check("R7 idx", isr_idx, 3'd5);
        check("R8 no early clr", c, 1'b0);
        pulse(1, 8'hB4, "R3 low byte", s, c);
        check("R8 no clr mid", c, 1'b0);
        pulse(1, 8'h12, "R5 high byte", s, c);
        check("R8 clr after third", c, 1'b1);
        @(negedge clk);
        check("R8 clr width", isr_clr, 1'b0);
    endtask

    task automatic t_cpu8_int8;
        bit s, c;
        cpu8_mode = 1; intvl4 = 0; aeoi = 0; lo_cfg = 8'hC0; vec_hi = 8'h77; win_irq = 3'd3;
        pulse(1, 8'hCD, "R10 restart call", s, c);
        check("R7 set 2nd seq", s, 1'b1);
        pulse(1, 8'hD8, "R4 low byte", s, c);
        pulse(1, 8'h77, "R5 high byte", s, c);
        check("R8 no clr without aeoi", c, 1'b0);
    endtask

    task automatic t_cpu16;
        bit s, c;
        cpu8_mode = 0; aeoi = 1; vec_hi = 8'h48; win_irq = 3'd6;
        pulse(0, 8'h00, "R6 first undriven", s, c);
        check("R7 set 16", s, 1'b1);
        check("R7 idx 16", isr_idx, 3'd6);
        pulse(1, 8'h4E, "R6 vector", s, c);
        check("R8 clr after second", c, 1'b1);
    endtask

    task automatic t_freeze;
        bit s, c;
        cpu8_mode = 1; intvl4 = 1; aeoi = 0; lo_cfg = 8'hA0; vec_hi = 8'h3C; win_irq = 3'd2;
        pulse(1, 8'hCD, "R10 call after 16", s, c);
        win_irq = 3'd7;
        pulse(1, 8'hA8, "R7 frozen low byte", s, c);
        check("R7 no set mid", s, 1'b0);
        check("R7 idx frozen", isr_idx, 3'd2);
        pulse(1, 8'h3C, "R5 high byte", s, c);
        pulse(1, 8'hCD, "R10 new sequence", s, c);
        check("R10 set again", s, 1'b1);
        check("R7 idx new", isr_idx, 3'd7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cpu8_int4();
        t_cpu8_int8();
        t_cpu16();
        t_freeze();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule